// File: doc/BRIEF.md
# Memory-Card Host Control Register

This block holds the 32-bit control word of a memory-card host controller. Software reaches it through a plain bus-clock register port: a one-cycle write strobe with a data word, and a read word that always reflects the current contents. The stored fields drive the rest of the controller directly. These fields cover the global interrupt gate, the DMA mode selects, the regulator voltage codes, the open-drain pull-up control and the card-command request bits.

Five bits clear themselves, and each one has its own rule. The DMA interface reset drops after a fixed number of bus cycles. The FIFO reset waits for the FIFO to report that its pointers are cleared. The abort-read and IRQ-response requests wait for a completion handshake from the data and command state machines. The controller reset is a request carried into the card clock domain, where it is held for a minimum number of card cycles. An acknowledge comes back into the bus domain, and the bit clears only after the bus-side minimum has also passed. While the controller reset is pending, three of the register's own bits are held at zero and the command register's start bit is told to clear.

Top module: `mch_ctrl_reg`

## Requirements
- R1: After reset every bit reads 0. Reserved bits 3, 15:12 and 31:26 always read 0 and ignore writes.
- R2: A write loads the written value into the plain fields: bit 4 interrupt enable, bit 5 DMA enable, bit 6 read wait, bit 9 CCSD request, bit 10 auto-stop CCSD request, bit 11 CE-ATA interrupt status, bits 19:16 regulator A, bits 23:20 regulator B, bit 24 pull-up enable and bit 25 internal DMA select.
- R3: Writing 0 to a self-clearing bit (bit 0 controller reset, bit 1 FIFO reset, bit 2 DMA reset, bit 7 IRQ response, bit 8 abort read) leaves it unchanged.
- R4: Once set, the DMA reset bit (bit 2) reads 1 for exactly DMA_RST_CYC bus cycles, then 0. It is driven on `dma_rst_o`.
- R5: Once set, the controller reset bit (bit 0) stays 1 until at least BUS_RST_CYC bus cycles have passed and the card domain has held `ctrl_rst_card_o` for at least CARD_RST_CYC card cycles. It then clears by itself.
- R6: While bit 0 is 1, bits 8:6 read 0 and ignore writes, and `cmd_start_clr_o` is 1. All other fields keep their values.
- R7: The FIFO reset bit (bit 1) clears on the cycle after `fifo_ptr_rst_done` is sampled high.
- R8: The abort read bit (bit 8) clears on the cycle after `data_fsm_idle` is sampled high.
- R9: The IRQ response bit (bit 7) clears on the cycle after `irq_resp_sent` is sampled high.
- R10: A write of 1 to a self-clearing bit in the same cycle as its clear condition leaves the bit set.
- R11: `intr_o` is 1 exactly when bit 4 is 1 and `irq_pending` is 1.
- R12: `od_pullup_n_o` is the inverse of bit 24. `volt_a_o` and `volt_b_o` equal bits 19:16 and 23:20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bus clock |
| brst_n | input | 1 | Bus-domain asynchronous reset, active low |
| cclk | input | 1 | Card clock |
| crst_n | input | 1 | Card-domain asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one bus cycle per write |
| wr_data | input | 32 | Write data word |
| rd_data | output | 32 | Current register contents |
| fifo_ptr_rst_done | input | 1 | FIFO reports that its pointer reset is complete |
| data_fsm_idle | input | 1 | Data state machine reports that it has returned to idle |
| irq_resp_sent | input | 1 | Command state machine reports that the IRQ response has been sent |
| irq_pending | input | 1 | At least one unmasked interrupt is pending |
| intr_o | output | 1 | Gated interrupt output |
| ctrl_rst_card_o | output | 1 | Controller reset in the card clock domain |
| cmd_start_clr_o | output | 1 | Clears the command register start bit |
| fifo_rst_o | output | 1 | FIFO pointer reset request |
| dma_rst_o | output | 1 | DMA interface reset |
| dma_en_o | output | 1 | DMA transfer mode enable |
| read_wait_o | output | 1 | Read-wait assertion |
| irq_resp_req_o | output | 1 | Request to send the IRQ response |
| abort_rd_o | output | 1 | Request to abort the read data state machine |
| ccsd_req_o | output | 1 | Request to send a completion-signal disable |
| ccsd_stop_req_o | output | 1 | Request for an automatic stop after the disable |
| ceata_int_en_o | output | 1 | CE-ATA device interrupt status |
| volt_a_o | output | 4 | Regulator A voltage code |
| volt_b_o | output | 4 | Regulator B voltage code |
| od_pullup_n_o | output | 1 | Open-drain pull-up enable, active low |
| int_dma_sel_o | output | 1 | Selects the internal DMA engine |

## Verification
The assertions assume that each completion handshake is raised only while the bit it clears is set. They also assume that both clocks run freely and that the two resets are released together. Under those conditions, the checks on hold time, clearing and write priority describe only this block. The stimulus raises each handshake as a one-cycle pulse, and only after the matching bit has been read back as 1. It always issues a write as a single-cycle strobe away from the clock edge. It also lets a controller reset finish before it starts the next one.

// File: rtl/mch_ctrl_pkg.sv
package mch_ctrl_pkg;
  localparam int REG_W  = 32;
  localparam int VOLT_W = 4;

  // bit positions decoded by the rest of the controller
  localparam int B_CRST   = 0;
  localparam int B_FIFO   = 1;
  localparam int B_DMA    = 2;
  localparam int B_INTEN  = 4;
  localparam int B_DMAEN  = 5;
  localparam int B_RWAIT  = 6;
  localparam int B_IRQRSP = 7;
  localparam int B_ABORT  = 8;
  localparam int B_CCSD   = 9;
  localparam int B_ASTOP  = 10;
  localparam int B_CEATA  = 11;
  localparam int B_VA_LO  = 16;
  localparam int B_VB_LO  = 20;
  localparam int B_PULL   = 24;
  localparam int B_IDMA   = 25;

  localparam logic [REG_W-1:0] RSVD_MASK = 32'hFC00_F008;
endpackage

// File: rtl/mch_ctrl_sync.sv
module mch_ctrl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ff <= '0;
    end else begin
      ff[0] <= d_i;
      for (int i = 1; i < STAGES; i++) ff[i] <= ff[i-1];
    end
  end

  assign q_o = ff[STAGES-1];
endmodule

// File: rtl/mch_ctrl_scbit.sv
// One self-clearing control bit: set by a write of 1, cleared either by an
// external handshake or, in timed mode, after CYC cycles; a forced zero wins.
module mch_ctrl_scbit #(
  parameter bit TIMED = 1'b0,
  parameter int CYC   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic ext_clr_i,
  input  logic force_zero_i,
  output logic q_o
);
  localparam int CW = (CYC > 1) ? $clog2(CYC) : 1;

  logic clr;

  generate
    if (TIMED) begin : g_timed
      logic [CW-1:0] cnt;
      logic          last;

      assign last = (cnt == CW'(CYC - 1));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt <= '0;
        else if (set_i || !q_o) cnt <= '0;
        else                    cnt <= cnt + 1'b1;
      end

      assign clr = q_o && (ext_clr_i || last);

      assert_timed_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        q_o && last && !set_i |=> !q_o);
      assert_timed_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        q_o && !last && !set_i && !ext_clr_i && !force_zero_i |=> q_o);
    end else begin : g_hs
      assign clr = ext_clr_i;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            q_o <= 1'b0;
    else if (force_zero_i) q_o <= 1'b0;
    else if (set_i)        q_o <= 1'b1;
    else if (clr)          q_o <= 1'b0;
  end

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    set_i && !force_zero_i |=> q_o);
  // handshake clear, shared by the FIFO (R7), abort (R8) and IRQ (R9) bits
  assert_hs_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    q_o && ext_clr_i && !set_i |=> !q_o);
endmodule

// File: rtl/mch_ctrl_xrst.sv
// Controller reset bit: bus-side minimum count, request synchronized into the
// card domain, card-side minimum count, acknowledge synchronized back.
module mch_ctrl_xrst #(
  parameter int BUS_CYC  = 2,
  parameter int CARD_CYC = 2,
  parameter int STAGES   = 2
) (
  input  logic bclk,
  input  logic brst_n,
  input  logic cclk,
  input  logic crst_n,
  input  logic set_i,
  output logic bit_o,
  output logic card_rst_o
);
  localparam int BCW = $clog2(BUS_CYC + 1);
  localparam int CCW = $clog2(CARD_CYC + 1);

  logic           bit_q, drain_q, req_q, ack_s, bus_done, clr_fire;
  logic [BCW-1:0] bcnt;
  logic           req_s, ack_q;
  logic [CCW-1:0] ccnt;

  // ---------------- bus domain ----------------
  assign bus_done = (bcnt == BCW'(BUS_CYC));
  assign clr_fire = bit_q && req_q && bus_done && ack_s;

  always_ff @(posedge bclk or negedge brst_n) begin
    if (!brst_n) begin
      bit_q   <= 1'b0;
      drain_q <= 1'b0;
      req_q   <= 1'b0;
      bcnt    <= '0;
    end else begin
      req_q <= bit_q && !drain_q && !clr_fire;
      if (set_i)         bit_q <= 1'b1;
      else if (clr_fire) bit_q <= 1'b0;
      if (clr_fire)               drain_q <= 1'b1;
      else if (!ack_s && !req_q)  drain_q <= 1'b0;
      if (!req_q)         bcnt <= '0;
      else if (!bus_done) bcnt <= bcnt + 1'b1;
    end
  end

  mch_ctrl_sync #(.STAGES(STAGES)) u_ack_sync (
    .clk(bclk), .rst_n(brst_n), .d_i(ack_q), .q_o(ack_s));

  // ---------------- card domain ----------------
  mch_ctrl_sync #(.STAGES(STAGES)) u_req_sync (
    .clk(cclk), .rst_n(crst_n), .d_i(req_q), .q_o(req_s));

  always_ff @(posedge cclk or negedge crst_n) begin
    if (!crst_n) begin
      ccnt  <= '0;
      ack_q <= 1'b0;
    end else begin
      ack_q <= req_s && (ccnt == CCW'(CARD_CYC));
      if (!req_s)                       ccnt <= '0;
      else if (ccnt != CCW'(CARD_CYC))  ccnt <= ccnt + 1'b1;
    end
  end

  assign bit_o      = bit_q;
  assign card_rst_o = req_s;

  assert_crst_waits_ack_R5: assert property (@(posedge bclk) disable iff (!brst_n)
    bit_q && !ack_s |=> bit_q);
  assert_crst_bus_min_R5: assert property (@(posedge bclk) disable iff (!brst_n)
    bit_q && !bus_done |=> bit_q);
  assert_card_ack_R5: assert property (@(posedge cclk) disable iff (!crst_n)
    ack_q |-> $past(req_s));
endmodule

// File: rtl/mch_ctrl_reg.sv
module mch_ctrl_reg
  import mch_ctrl_pkg::*;
#(
  parameter int DMA_RST_CYC  = 2,
  parameter int BUS_RST_CYC  = 2,
  parameter int CARD_RST_CYC = 2,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                  bclk,
  input  logic                  brst_n,
  input  logic                  cclk,
  input  logic                  crst_n,
  input  logic                  wr_en,
  input  logic [REG_W-1:0]      wr_data,
  output logic [REG_W-1:0]      rd_data,
  input  logic                  fifo_ptr_rst_done,
  input  logic                  data_fsm_idle,
  input  logic                  irq_resp_sent,
  input  logic                  irq_pending,
  output logic                  intr_o,
  output logic                  ctrl_rst_card_o,
  output logic                  cmd_start_clr_o,
  output logic                  fifo_rst_o,
  output logic                  dma_rst_o,
  output logic                  dma_en_o,
  output logic                  read_wait_o,
  output logic                  irq_resp_req_o,
  output logic                  abort_rd_o,
  output logic                  ccsd_req_o,
  output logic                  ccsd_stop_req_o,
  output logic                  ceata_int_en_o,
  output logic [VOLT_W-1:0]     volt_a_o,
  output logic [VOLT_W-1:0]     volt_b_o,
  output logic                  od_pullup_n_o,
  output logic                  int_dma_sel_o
);
  logic crst_q, crst_hold;
  logic fifo_q, dma_q, irq_q, abort_q;
  logic int_en_q, dma_en_q, rwait_q, ccsd_q, astop_q, ceata_q, pull_q, idma_q;
  logic [VOLT_W-1:0] va_q, vb_q;
  logic unused_rsvd_wr;

  assign unused_rsvd_wr = ^(wr_data & RSVD_MASK);

  // controller reset spans both clock domains
  mch_ctrl_xrst #(
    .BUS_CYC(BUS_RST_CYC), .CARD_CYC(CARD_RST_CYC), .STAGES(SYNC_STAGES)
  ) u_xrst (
    .bclk(bclk), .brst_n(brst_n), .cclk(cclk), .crst_n(crst_n),
    .set_i(wr_en && wr_data[B_CRST]),
    .bit_o(crst_q), .card_rst_o(ctrl_rst_card_o));

  // pending or just-written controller reset holds bits 8:6 at zero
  assign crst_hold = crst_q || (wr_en && wr_data[B_CRST]);

  mch_ctrl_scbit #(.TIMED(1'b1), .CYC(DMA_RST_CYC)) u_dma (
    .clk(bclk), .rst_n(brst_n), .set_i(wr_en && wr_data[B_DMA]),
    .ext_clr_i(1'b0), .force_zero_i(1'b0), .q_o(dma_q));

  mch_ctrl_scbit #(.TIMED(1'b0), .CYC(1)) u_fifo (
    .clk(bclk), .rst_n(brst_n), .set_i(wr_en && wr_data[B_FIFO]),
    .ext_clr_i(fifo_ptr_rst_done), .force_zero_i(1'b0), .q_o(fifo_q));

  mch_ctrl_scbit #(.TIMED(1'b0), .CYC(1)) u_irq (
    .clk(bclk), .rst_n(brst_n), .set_i(wr_en && wr_data[B_IRQRSP]),
    .ext_clr_i(irq_resp_sent), .force_zero_i(crst_hold), .q_o(irq_q));

  mch_ctrl_scbit #(.TIMED(1'b0), .CYC(1)) u_abort (
    .clk(bclk), .rst_n(brst_n), .set_i(wr_en && wr_data[B_ABORT]),
    .ext_clr_i(data_fsm_idle), .force_zero_i(crst_hold), .q_o(abort_q));

  // plain read/write fields
  always_ff @(posedge bclk or negedge brst_n) begin
    if (!brst_n) begin
      int_en_q <= 1'b0;
      dma_en_q <= 1'b0;
      rwait_q  <= 1'b0;
      ccsd_q   <= 1'b0;
      astop_q  <= 1'b0;
      ceata_q  <= 1'b0;
      va_q     <= '0;
      vb_q     <= '0;
      pull_q   <= 1'b0;
      idma_q   <= 1'b0;
    end else begin
      if (wr_en) begin
        int_en_q <= wr_data[B_INTEN];
        dma_en_q <= wr_data[B_DMAEN];
        ccsd_q   <= wr_data[B_CCSD];
        astop_q  <= wr_data[B_ASTOP];
        ceata_q  <= wr_data[B_CEATA];
        va_q     <= wr_data[B_VA_LO +: VOLT_W];
        vb_q     <= wr_data[B_VB_LO +: VOLT_W];
        pull_q   <= wr_data[B_PULL];
        idma_q   <= wr_data[B_IDMA];
      end
      if (crst_hold)  rwait_q <= 1'b0;
      else if (wr_en) rwait_q <= wr_data[B_RWAIT];
    end
  end

  always_comb begin
    rd_data                     = '0;
    rd_data[B_CRST]             = crst_q;
    rd_data[B_FIFO]             = fifo_q;
    rd_data[B_DMA]              = dma_q;
    rd_data[B_INTEN]            = int_en_q;
    rd_data[B_DMAEN]            = dma_en_q;
    rd_data[B_RWAIT]            = rwait_q;
    rd_data[B_IRQRSP]           = irq_q;
    rd_data[B_ABORT]            = abort_q;
    rd_data[B_CCSD]             = ccsd_q;
    rd_data[B_ASTOP]            = astop_q;
    rd_data[B_CEATA]            = ceata_q;
    rd_data[B_VA_LO +: VOLT_W]  = va_q;
    rd_data[B_VB_LO +: VOLT_W]  = vb_q;
    rd_data[B_PULL]             = pull_q;
    rd_data[B_IDMA]             = idma_q;
  end

  assign intr_o          = int_en_q && irq_pending;
  assign cmd_start_clr_o = crst_q;
  assign fifo_rst_o      = fifo_q;
  assign dma_rst_o       = dma_q;
  assign dma_en_o        = dma_en_q;
  assign read_wait_o     = rwait_q;
  assign irq_resp_req_o  = irq_q;
  assign abort_rd_o      = abort_q;
  assign ccsd_req_o      = ccsd_q;
  assign ccsd_stop_req_o = astop_q;
  assign ceata_int_en_o  = ceata_q;
  assign volt_a_o        = va_q;
  assign volt_b_o        = vb_q;
  assign od_pullup_n_o   = !pull_q;
  assign int_dma_sel_o   = idma_q;

  assert_rsvd_zero_R1: assert property (@(posedge bclk) disable iff (!brst_n)
    (rd_data & RSVD_MASK) == '0);
  assert_plain_write_R2: assert property (@(posedge bclk) disable iff (!brst_n)
    wr_en |=> rd_data[B_IDMA:B_VA_LO] == $past(wr_data[B_IDMA:B_VA_LO]));
  assert_zero_no_effect_R3: assert property (@(posedge bclk) disable iff (!brst_n)
    wr_en && !wr_data[B_FIFO] && fifo_q && !fifo_ptr_rst_done |=> fifo_q);
  assert_crst_side_R6: assert property (@(posedge bclk) disable iff (!brst_n)
    crst_q |-> rd_data[B_ABORT:B_RWAIT] == 3'b000);
  assert_intr_gate_R11: assert property (@(posedge bclk) disable iff (!brst_n)
    intr_o |-> irq_pending && rd_data[B_INTEN]);
  assert_pullup_inv_R12: assert property (@(posedge bclk) disable iff (!brst_n)
    od_pullup_n_o != rd_data[B_PULL]);
endmodule

// File: tb/sim_mch_ctrl_reg.sv
module sim_mch_ctrl_reg;
  logic        bclk = 1'b0, cclk = 1'b0;
  logic        brst_n = 1'b0, crst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        fifo_ptr_rst_done = 1'b0, data_fsm_idle = 1'b0, irq_resp_sent = 1'b0;
  logic        irq_pending = 1'b0;
  logic [31:0] rd_data;
  logic        intr_o, ctrl_rst_card_o, cmd_start_clr_o, fifo_rst_o, dma_rst_o;
  logic        dma_en_o, read_wait_o, irq_resp_req_o, abort_rd_o, ccsd_req_o;
  logic        ccsd_stop_req_o, ceata_int_en_o, od_pullup_n_o, int_dma_sel_o;
  logic [3:0]  volt_a_o, volt_b_o;

  always #2 bclk = ~bclk;
  always #5 cclk = ~cclk;

  mch_ctrl_reg u0 (
    .bclk(bclk), .brst_n(brst_n), .cclk(cclk), .crst_n(crst_n),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .fifo_ptr_rst_done(fifo_ptr_rst_done), .data_fsm_idle(data_fsm_idle),
    .irq_resp_sent(irq_resp_sent), .irq_pending(irq_pending), .intr_o(intr_o),
    .ctrl_rst_card_o(ctrl_rst_card_o), .cmd_start_clr_o(cmd_start_clr_o),
    .fifo_rst_o(fifo_rst_o), .dma_rst_o(dma_rst_o), .dma_en_o(dma_en_o),
    .read_wait_o(read_wait_o), .irq_resp_req_o(irq_resp_req_o),
    .abort_rd_o(abort_rd_o), .ccsd_req_o(ccsd_req_o),
    .ccsd_stop_req_o(ccsd_stop_req_o), .ceata_int_en_o(ceata_int_en_o),
    .volt_a_o(volt_a_o), .volt_b_o(volt_b_o), .od_pullup_n_o(od_pullup_n_o),
    .int_dma_sel_o(int_dma_sel_o));

  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        card_seen = 1'b0;

  always @(posedge cclk) if (ctrl_rst_card_o) card_seen = 1'b1;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard driver side: expected read word queued for the monitor
  task automatic expect_rd(logic [31:0] e, string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // monitor: pops each expectation and compares it with the read port
  initial forever begin
    wait (exp_q.size() != 0);
    check(tag_q.pop_front(), rd_data, exp_q.pop_front());
  end

  // one-cycle stimulus, starting and ending at a falling edge
  task automatic drive(logic we, logic [31:0] d, logic f, logic a, logic i);
    wr_en = we; wr_data = d;
    fifo_ptr_rst_done = f; data_fsm_idle = a; irq_resp_sent = i;
    @(negedge bclk);
    wr_en = 1'b0; fifo_ptr_rst_done = 1'b0; data_fsm_idle = 1'b0; irq_resp_sent = 1'b0;
  endtask

  task automatic wr(logic [31:0] d);
    drive(1'b1, d, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge bclk);
  endtask

  task automatic run_crst(logic [31:0] wdata, logic [31:0] keep, string tag);
    int waited = 0;
    card_seen = 1'b0;
    wr(wdata);
    expect_rd(keep | 32'h1, {tag, " R6 bits 8:6 held at zero"});
    check({tag, " R6 start clear"}, 32'(cmd_start_clr_o), 32'd1);
    while (rd_data[0] && waited < 400) begin
      @(negedge bclk);
      waited++;
    end
    check({tag, " R5 bit cleared"}, 32'(rd_data[0]), 32'd0);
    check({tag, " R5 bus minimum"}, 32'(waited >= 2), 32'd1);
    check({tag, " R5 card reset seen"}, 32'(card_seen), 32'd1);
    expect_rd(keep, {tag, " R6 other fields kept"});
    tick(30);
  endtask

  initial begin
    repeat (100000) @(posedge bclk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    tick(3);
    brst_n = 1'b1; crst_n = 1'b1;
    tick(1);

    // R1 reset state
    expect_rd(32'h0, "R1 reset value");
    check("R12 pull-up port after reset", 32'(od_pullup_n_o), 32'd1);
    irq_pending = 1'b1;
    tick(1);
    check("R11 gated off after reset", 32'(intr_o), 32'd0);

    // R1/R2 all plain and reserved bits written
    wr(32'hFFFF_FE78);
    expect_rd(32'h03FF_0E70, "R2 plain fields load, R1 reserved read 0");
    check("R11 interrupt enabled and pending", 32'(intr_o), 32'd1);
    check("R12 pull-up port inverted", 32'(od_pullup_n_o), 32'd0);
    check("R2 internal DMA select", 32'(int_dma_sel_o), 32'd1);
    check("R2 CCSD request ports", {30'd0, ccsd_req_o, ccsd_stop_req_o}, 32'd3);

    wr(32'h0000_0010);
    irq_pending = 1'b0;
    tick(1);
    check("R11 enabled but nothing pending", 32'(intr_o), 32'd0);
    irq_pending = 1'b1;

    // R12 voltage codes
    wr(32'h00A5_0000);
    expect_rd(32'h00A5_0000, "R2 voltage fields");
    check("R12 regulator A", 32'(volt_a_o), 32'h5);
    check("R12 regulator B", 32'(volt_b_o), 32'hA);
    check("R11 interrupt disabled", 32'(intr_o), 32'd0);

    // R4 timed DMA reset
    wr(32'h00A5_0004);
    expect_rd(32'h00A5_0004, "R4 DMA reset cycle 1");
    check("R4 DMA reset port", 32'(dma_rst_o), 32'd1);
    tick(1);
    expect_rd(32'h00A5_0004, "R4 DMA reset cycle 2");
    tick(1);
    expect_rd(32'h00A5_0000, "R4 DMA reset cleared");

    // R7 FIFO reset handshake, R3 zero write, R10 write wins
    wr(32'h00A5_0002);
    tick(3);
    expect_rd(32'h00A5_0002, "R7 FIFO reset held until done");
    wr(32'h00A5_0000);
    expect_rd(32'h00A5_0002, "R3 write of 0 ignored");
    drive(1'b1, 32'h00A5_0002, 1'b1, 1'b0, 1'b0);
    expect_rd(32'h00A5_0002, "R10 write beats FIFO clear");
    drive(1'b0, 32'h0, 1'b1, 1'b0, 1'b0);
    expect_rd(32'h00A5_0000, "R7 FIFO reset cleared by done");
    check("R7 FIFO reset port", 32'(fifo_rst_o), 32'd0);

    // R8 abort read
    wr(32'h00A5_0100);
    expect_rd(32'h00A5_0100, "R8 abort set");
    drive(1'b0, 32'h0, 1'b0, 1'b1, 1'b0);
    expect_rd(32'h00A5_0000, "R8 abort cleared by idle");

    // R9 IRQ response, R10 on this bit too
    wr(32'h00A5_0080);
    check("R9 IRQ response port", 32'(irq_resp_req_o), 32'd1);
    drive(1'b1, 32'h00A5_0080, 1'b0, 1'b0, 1'b1);
    expect_rd(32'h00A5_0080, "R10 write beats IRQ clear");
    drive(1'b0, 32'h0, 1'b0, 1'b0, 1'b1);
    expect_rd(32'h00A5_0000, "R9 IRQ response cleared by sent");

    // R5/R6 controller reset across domains
    wr(32'h00A5_01C0);
    expect_rd(32'h00A5_01C0, "R6 bits 8:6 set before reset");
    run_crst(32'h00A5_0041, 32'h00A5_0000, "first");
    run_crst(32'h00A5_0011, 32'h00A5_0010, "second");
    check("R11 interrupt kept through reset", 32'(intr_o), 32'd1);

    tick(2);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule